// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block connects a simple host register port to an on-chip flash array. The host writes byte command codes. The block then selects the main or the information block of the array, programs one byte, erases one page, or switches the host read path between array data and an 8-bit status byte. Program and erase each take two host writes: the command code first, then a write that carries the target address and the data byte. Before the block hands the operation to the flash side, it checks the target against a protected page window and against the information-block lock.

The flash side uses a start/done handshake. `fl_start` pulses for one cycle together with a mode, an address, a data byte and the block select. The block holds those values stable until `fl_done` pulses. While no command write is pending, every host write is taken as a command code and `host_addr` is ignored.

The status byte has these fields: bit 7 BUSY, bit 6 command error, bit 5 protect error, bit 4 setup error, bit 3 INFO (the selected block, 1 = information block). Bits 2..0 read as zero. The three error bits are sticky.

The sequencer has four states:
- `SEQ_RD_STATUS`: idle, and host reads return the status byte.
- `SEQ_RD_ARRAY`: idle, and host reads return array data.
- `SEQ_SETUP`: the command code has been taken and the block waits for the address/data write.
- `SEQ_EXEC`: the flash operation is in progress.

Its transitions are:
- Launch: `SEQ_SETUP` goes to `SEQ_EXEC` on an address/data write whose target is not protected.
- Refuse: `SEQ_SETUP` goes to `SEQ_RD_STATUS` on an address/data write whose target is protected.
- Abort: `SEQ_SETUP` goes to `SEQ_RD_STATUS` on a host read.
- Complete: `SEQ_EXEC` goes to `SEQ_RD_STATUS` on `fl_done`.
- Enter array read: either idle state goes to `SEQ_RD_ARRAY` on the read-array code.
- Return to status: either idle state goes to `SEQ_RD_STATUS` on clear-status, select-main, select-info or a reserved code.
- Begin setup: either idle state goes to `SEQ_SETUP` on the program or erase code.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte reads 0x00, `fl_mode` is 0 (standby), `fl_start` is low and `fl_info` is 0 (main block).
- R2: Command 0x61 sets INFO (bit 3) and command 0x60 clears it. `fl_info` follows INFO. After either command, host reads return the status byte and `fl_mode` stays 0 (standby).
- R3: Command 0x10 followed by a write of address and data launches a program operation. `fl_start` is high for exactly one cycle, with `fl_mode` = 2, `fl_addr` = the written address and `fl_wdata` = the written data. BUSY (bit 7) is set from that cycle until the cycle after `fl_done`.
- R4: Command 0x20 followed by an address write launches an erase operation with `fl_mode` = 3 and `fl_addr` = the written address, and BUSY behaves as in R3.
- R5: A host write while BUSY is set changes nothing in the running operation: `fl_mode`, `fl_addr` and `fl_wdata` stay the same and no further operation starts. The write sets the command-error bit (bit 6).
- R6: While idle, a code other than 0x10, 0x20, 0x30, 0x50, 0x60 or 0x61 sets the command-error bit, starts nothing and returns the host read path to status.
- R7: A program or erase whose page (`addr >> OFS_W`) lies within `prot_lo_page`..`prot_hi_page` inclusive, while the main block is selected, is refused. The block sets the protect-error bit (bit 5), starts nothing and returns to status read.
- R8: While the information block is selected, every program or erase is refused as in R7 unless `info_unlock` is high. With `info_unlock` high, the operation is launched with `fl_info` = 1.
- R9: If the write that follows a program or erase code is replaced by a host read, the command is dropped, the setup-error bit (bit 4) is set and nothing starts.
- R10: The error bits stay set through later commands. Only command 0x50, accepted while BUSY is clear, clears them, and it leaves INFO unchanged. A 0x50 written while BUSY is set is handled as in R5.
- R11: Command 0x30 makes `host_rdata` return `fl_rdata` with `fl_mode` = 1 and `fl_addr` = `host_addr`, until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host address for the address/data write and for array reads |
| host_wdata | input | 8 | Host write data: a command code or a program data byte |
| host_rdata | output | 8 | Status byte, or array data in array-read mode |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| prot_lo_page | input | ADDR_W-OFS_W | Lowest protected page of the main block |
| prot_hi_page | input | ADDR_W-OFS_W | Highest protected page of the main block |
| info_unlock | input | 1 | Allows program and erase of the information block |
| fl_mode | output | 2 | Flash mode: 0 standby, 1 read, 2 program, 3 erase |
| fl_info | output | 1 | Flash block select (1 = information block) |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash program data |
| fl_rdata | input | 8 | Flash read data |
| fl_start | output | 1 | One-cycle launch pulse |
| fl_done | input | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the rules that hold whatever the host does:
- a launch always carries a program or erase mode together with BUSY;
- the flash-side values are frozen while an operation runs;
- a write during BUSY always raises the command error;
- BUSY falls right after `fl_done`;
- the flash side is in standby whenever the block is idle in status mode;
- a command-error bit can fall only after an accepted clear.

Some behaviour can only be shown by the bench's directed scenarios with a delayed-done responder and a bench-side count of launches:
- which codes count as reserved;
- the inclusive protection window and the information-block lock;
- the abort on a read during setup;
- the unchanged operation after a rejected write;
- INFO after each select command.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_RD_STATUS = 2'd0,
        SEQ_RD_ARRAY  = 2'd1,
        SEQ_SETUP     = 2'd2,
        SEQ_EXEC      = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        CK_PROG,
        CK_ERASE,
        CK_READ,
        CK_CLEAR,
        CK_SEL_MAIN,
        CK_SEL_INFO,
        CK_RSVD
    } cmd_kind_t;

    typedef enum logic [1:0] {
        FM_STANDBY = 2'd0,
        FM_READ    = 2'd1,
        FM_PROG    = 2'd2,
        FM_ERASE   = 2'd3
    } fl_mode_t;

    localparam logic [7:0] CODE_PROG     = 8'h10;
    localparam logic [7:0] CODE_ERASE    = 8'h20;
    localparam logic [7:0] CODE_READ     = 8'h30;
    localparam logic [7:0] CODE_CLEAR    = 8'h50;
    localparam logic [7:0] CODE_SEL_MAIN = 8'h60;
    localparam logic [7:0] CODE_SEL_INFO = 8'h61;

    localparam int ST_BUSY_BIT  = 7;
    localparam int ST_CMD_BIT   = 6;
    localparam int ST_PROT_BIT  = 5;
    localparam int ST_SETUP_BIT = 4;
    localparam int ST_INFO_BIT  = 3;

endpackage

// File: rtl/flash_cmd_decode.sv
`timescale 1ns/1ps
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_kind_t  kind
);

    always_comb begin
        unique case (code)
            CODE_PROG:     kind = CK_PROG;
            CODE_ERASE:    kind = CK_ERASE;
            CODE_READ:     kind = CK_READ;
            CODE_CLEAR:    kind = CK_CLEAR;
            CODE_SEL_MAIN: kind = CK_SEL_MAIN;
            CODE_SEL_INFO: kind = CK_SEL_INFO;
            default:       kind = CK_RSVD;
        endcase
    end

endmodule

// File: rtl/flash_prot_check.sv
`timescale 1ns/1ps
module flash_prot_check #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 4,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] lo_page,
    input  logic [PAGE_W-1:0] hi_page,
    input  logic              info_sel,
    input  logic              info_unlock,
    output logic              is_protected
);

    logic [PAGE_W-1:0] page;
    logic              in_window;

    assign page      = addr[ADDR_W-1:OFS_W];
    assign in_window = (page >= lo_page) && (page <= hi_page);

    always_comb begin
        if (info_sel) begin
            is_protected = !info_unlock;
        end else begin
            is_protected = in_window;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 4,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [PAGE_W-1:0] prot_lo_page,
    input  logic [PAGE_W-1:0] prot_hi_page,
    input  logic              info_unlock,
    output logic [1:0]        fl_mode,
    output logic              fl_info,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              fl_start,
    input  logic              fl_done
);

    seq_state_t        state_q, state_d;
    cmd_kind_t         kind;
    logic              target_prot;

    // registered datapath
    logic              erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              info_q;
    logic              cmd_err_q, prot_err_q, setup_err_q;
    logic              start_q;

    // transition strobes
    logic              go_setup_prog, go_setup_erase;
    logic              launch;
    logic              set_cmd_err, set_prot_err, set_setup_err;
    logic              clr_errs, sel_main, sel_info;

    // status view shared with the checker
    logic [7:0]        status_w;
    logic              array_mode_w;

    flash_cmd_decode u_decode (
        .code (host_wdata),
        .kind (kind)
    );

    flash_prot_check #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_prot (
        .addr         (host_addr),
        .lo_page      (prot_lo_page),
        .hi_page      (prot_hi_page),
        .info_sel     (info_q),
        .info_unlock  (info_unlock),
        .is_protected (target_prot)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_RD_STATUS;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d        = state_q;
        go_setup_prog  = 1'b0;
        go_setup_erase = 1'b0;
        launch         = 1'b0;
        set_cmd_err    = 1'b0;
        set_prot_err   = 1'b0;
        set_setup_err  = 1'b0;
        clr_errs       = 1'b0;
        sel_main       = 1'b0;
        sel_info       = 1'b0;
        unique case (state_q)
            SEQ_RD_STATUS, SEQ_RD_ARRAY: begin
                if (host_wr) begin
                    unique case (kind)
                        CK_PROG: begin
                            go_setup_prog = 1'b1;
                            state_d       = SEQ_SETUP;
                        end
                        CK_ERASE: begin
                            go_setup_erase = 1'b1;
                            state_d        = SEQ_SETUP;
                        end
                        CK_READ: state_d = SEQ_RD_ARRAY;
                        CK_CLEAR: begin
                            clr_errs = 1'b1;
                            state_d  = SEQ_RD_STATUS;
                        end
                        CK_SEL_MAIN: begin
                            sel_main = 1'b1;
                            state_d  = SEQ_RD_STATUS;
                        end
                        CK_SEL_INFO: begin
                            sel_info = 1'b1;
                            state_d  = SEQ_RD_STATUS;
                        end
                        default: begin
                            set_cmd_err = 1'b1;
                            state_d     = SEQ_RD_STATUS;
                        end
                    endcase
                end
            end
            SEQ_SETUP: begin
                if (host_wr) begin
                    if (target_prot) begin
                        set_prot_err = 1'b1;
                        state_d      = SEQ_RD_STATUS;
                    end else begin
                        launch  = 1'b1;
                        state_d = SEQ_EXEC;
                    end
                end else if (host_rd) begin
                    set_setup_err = 1'b1;
                    state_d       = SEQ_RD_STATUS;
                end
            end
            SEQ_EXEC: begin
                if (host_wr) begin
                    set_cmd_err = 1'b1;
                end
                if (fl_done) begin
                    state_d = SEQ_RD_STATUS;
                end
            end
            default: state_d = SEQ_RD_STATUS;
        endcase
    end

    // datapath and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q     <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
            info_q      <= 1'b0;
            cmd_err_q   <= 1'b0;
            prot_err_q  <= 1'b0;
            setup_err_q <= 1'b0;
            start_q     <= 1'b0;
        end else begin
            start_q <= launch;
            if (go_setup_prog) begin
                erase_q <= 1'b0;
            end
            if (go_setup_erase) begin
                erase_q <= 1'b1;
            end
            if (launch) begin
                addr_q <= host_addr;
                data_q <= host_wdata;
            end
            if (sel_main) begin
                info_q <= 1'b0;
            end
            if (sel_info) begin
                info_q <= 1'b1;
            end
            if (clr_errs) begin
                cmd_err_q   <= 1'b0;
                prot_err_q  <= 1'b0;
                setup_err_q <= 1'b0;
            end
            if (set_cmd_err) begin
                cmd_err_q <= 1'b1;
            end
            if (set_prot_err) begin
                prot_err_q <= 1'b1;
            end
            if (set_setup_err) begin
                setup_err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        status_w               = 8'h00;
        status_w[ST_BUSY_BIT]  = (state_q == SEQ_EXEC);
        status_w[ST_CMD_BIT]   = cmd_err_q;
        status_w[ST_PROT_BIT]  = prot_err_q;
        status_w[ST_SETUP_BIT] = setup_err_q;
        status_w[ST_INFO_BIT]  = info_q;
        array_mode_w           = (state_q == SEQ_RD_ARRAY);

        fl_start = start_q;
        fl_info  = info_q;
        fl_wdata = data_q;
        unique case (state_q)
            SEQ_EXEC: begin
                fl_mode    = erase_q ? FM_ERASE : FM_PROG;
                fl_addr    = addr_q;
                host_rdata = status_w;
            end
            SEQ_RD_ARRAY: begin
                fl_mode    = FM_READ;
                fl_addr    = host_addr;
                host_rdata = fl_rdata;
            end
            default: begin
                fl_mode    = FM_STANDBY;
                fl_addr    = addr_q;
                host_rdata = status_w;
            end
        endcase
    end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
`timescale 1ns/1ps
module flash_cmd_seq_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic              fl_start,
    input logic              fl_done,
    input logic [1:0]        fl_mode,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic [7:0]        status,
    input logic              array_mode
);

    assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |-> (status[7] && (fl_mode == 2'd2 || fl_mode == 2'd3)));

    assert_done_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && fl_done) |=> !status[7]);

    assert_busy_write_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && host_wr && !fl_done) |=> status[6]);

    assert_busy_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !fl_done) |=> ($stable(fl_mode) && $stable(fl_addr) && $stable(fl_wdata)));

    assert_idle_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && !array_mode) |-> (fl_mode == 2'd0 && !fl_start));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> $past(host_wr && host_wdata == 8'h50 && !status[7]));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .fl_start   (fl_start),
    .fl_done    (fl_done),
    .fl_mode    (fl_mode),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .status     (status_w),
    .array_mode (array_mode_w)
);

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int ADDR_W = 12;
    localparam int OFS_W  = 4;
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int DLY    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              host_rd = 1'b0;
    logic              host_wr = 1'b0;
    logic [PAGE_W-1:0] prot_lo_page = 8'h10;
    logic [PAGE_W-1:0] prot_hi_page = 8'h20;
    logic              info_unlock = 1'b0;
    logic [1:0]        fl_mode;
    logic              fl_info;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0]        fl_wdata;
    logic [7:0]        fl_rdata;
    logic              fl_start;
    logic              fl_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int cnt    = 0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) uut (
        .clk (clk), .rst_n (rst_n),
        .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
        .host_rd (host_rd), .host_wr (host_wr),
        .prot_lo_page (prot_lo_page), .prot_hi_page (prot_hi_page),
        .info_unlock (info_unlock),
        .fl_mode (fl_mode), .fl_info (fl_info), .fl_addr (fl_addr),
        .fl_wdata (fl_wdata), .fl_rdata (fl_rdata),
        .fl_start (fl_start), .fl_done (fl_done)
    );

    // array model and delayed-done responder
    assign fl_rdata = fl_addr[7:0] ^ 8'h3C;

    always @(posedge clk) begin
        fl_done <= 1'b0;
        if (fl_start) begin
            starts <= starts + 1;
            cnt    <= DLY;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) fl_done <= 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = d; host_addr = a;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!host_rdata[7]) break;
        end
        chk("R3 busy clears", int'(host_rdata[7]), 0);
    endtask

    task automatic t_reset();
        chk("R1 status", host_rdata, 8'h00);
        chk("R1 mode", fl_mode, 0);
        chk("R1 start", fl_start, 0);
        chk("R1 info", fl_info, 0);
    endtask

    task automatic t_select();
        wr(8'h61, '0);
        chk("R2 info set", host_rdata, 8'h08);
        chk("R2 fl_info", fl_info, 1);
        chk("R2 standby", fl_mode, 0);
        wr(8'h60, '0);
        chk("R2 info clear", host_rdata, 8'h00);
        chk("R2 fl_info main", fl_info, 0);
    endtask

    task automatic t_program();
        int s0 = starts;
        wr(8'h10, '0);
        chk("R3 setup not busy", host_rdata, 8'h00);
        wr(8'hA5, 12'h0F0);
        chk("R3 start", fl_start, 1);
        chk("R3 mode", fl_mode, 2);
        chk("R3 addr", fl_addr, 12'h0F0);
        chk("R3 data", fl_wdata, 8'hA5);
        chk("R3 busy", host_rdata, 8'h80);
        @(negedge clk);
        chk("R3 start one cycle", fl_start, 0);
        wait_idle();
        chk("R3 status after", host_rdata, 8'h00);
        chk("R3 one launch", starts - s0, 1);
    endtask

    task automatic t_erase();
        wr(8'h20, '0);
        wr(8'h00, 12'h210);
        chk("R4 mode", fl_mode, 3);
        chk("R4 addr", fl_addr, 12'h210);
        chk("R4 busy", host_rdata[7], 1);
        wait_idle();
        chk("R4 idle mode", fl_mode, 0);
    endtask

    task automatic t_busy_write();
        int s0 = starts;
        wr(8'h10, '0);
        wr(8'h5A, 12'h0E3);
        wr(8'h20, 12'h7FF);
        chk("R5 mode kept", fl_mode, 2);
        chk("R5 addr kept", fl_addr, 12'h0E3);
        chk("R5 data kept", fl_wdata, 8'h5A);
        chk("R5 cmd err", host_rdata, 8'hC0);
        wr(8'h50, '0);
        chk("R10 clear while busy ignored", host_rdata[6], 1);
        wait_idle();
        repeat (8) @(negedge clk);
        chk("R5 no new op", starts - s0, 1);
        chk("R5 status", host_rdata, 8'h40);
        wr(8'h50, '0);
        chk("R10 clear", host_rdata, 8'h00);
    endtask

    task automatic t_reserved();
        int s0 = starts;
        wr(8'h77, '0);
        chk("R6 cmd err", host_rdata, 8'h40);
        chk("R6 standby", fl_mode, 0);
        wr(8'h30, 12'h010);
        wr(8'h11, 12'h010);
        chk("R6 back to status", host_rdata, 8'h40);
        repeat (3) @(negedge clk);
        chk("R6 no launch", starts - s0, 0);
        wr(8'h50, '0);
    endtask

    task automatic t_protect();
        int s0 = starts;
        wr(8'h10, '0);
        wr(8'h12, 12'h100);
        chk("R7 low bound", host_rdata, 8'h20);
        chk("R7 no start", fl_start, 0);
        wr(8'h50, '0);
        wr(8'h20, '0);
        wr(8'h00, 12'h20F);
        chk("R7 high bound", host_rdata, 8'h20);
        wr(8'h50, '0);
        repeat (3) @(negedge clk);
        chk("R7 no launch", starts - s0, 0);
        wr(8'h61, '0);
        wr(8'h10, '0);
        wr(8'h33, 12'h0F0);
        chk("R8 info locked", host_rdata, 8'h28);
        wr(8'h50, '0);
        info_unlock = 1'b1;
        wr(8'h10, '0);
        wr(8'h33, 12'h150);
        chk("R8 unlocked start", fl_start, 1);
        chk("R8 fl_info", fl_info, 1);
        wait_idle();
        info_unlock = 1'b0;
        chk("R8 status", host_rdata, 8'h08);
        wr(8'h60, '0);
    endtask

    task automatic t_setup_err();
        int s0 = starts;
        wr(8'h20, '0);
        rd();
        chk("R9 setup err", host_rdata, 8'h10);
        wr(8'h00, 12'h0F0);
        chk("R9 write after abort is command", host_rdata, 8'h50);
        wr(8'h61, '0);
        chk("R10 sticky", host_rdata, 8'h58);
        wr(8'h50, '0);
        chk("R10 clear keeps info", host_rdata, 8'h08);
        wr(8'h60, '0);
        repeat (3) @(negedge clk);
        chk("R9 no launch", starts - s0, 0);
    endtask

    task automatic t_read_array();
        wr(8'h30, '0);
        host_addr = 12'h123;
        @(negedge clk);
        chk("R11 mode", fl_mode, 1);
        chk("R11 addr", fl_addr, 12'h123);
        chk("R11 data", host_rdata, 8'h23 ^ 8'h3C);
        wr(8'h60, '0);
        chk("R11 left array mode", host_rdata, 8'h00);
        chk("R11 standby", fl_mode, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_program();
        t_erase();
        t_busy_write();
        t_reserved();
        t_protect();
        t_setup_err();
        t_read_array();
        summary();
    end

endmodule